// File: doc/BRIEF.md
# Programmable Dual Row-Delay Line

This block buffers a raster pixel stream so that a 3 x 3 neighbourhood is available on every pixel clock. Two 8-bit row delays sit in series and share one programmable length R (1 to 1024 pixels). The live pixel, the pixel one row back and the pixel two rows back each feed a three-column shift window. The result is nine taps for a downstream multiply-accumulate stage, which is not part of this block. A cascade output carries the pixel delayed by two rows, so further delay stages can chain onto it.

A bypass mode takes the two older rows from an external 16-bit bus instead of the internal delays. This serves rows longer than the internal storage. A frame-clear input empties the delay lines between images and keeps the programmed length. A hold input freezes the whole pipeline one cycle after it is sampled. The row-length register can be written once per reset, and only within a fixed window of clocks after reset. Setting R = 3 lines the nine taps up as nine consecutive samples, which gives a one-dimensional 9-tap window.

Top module: `dual_row_delay`

## Requirements
- R1: While reset is asserted, and right after it, all taps and the cascade output are zero and the length code is 0.
- R2: Tap layout: `taps_o[8*(3*row+col) +: 8]`. Row 0 is the live pixel, row 1 is the pixel R steps older and row 2 is the pixel 2R steps older. Column 0 is the newest, and each column takes the previous column's value one step later. Each tap is registered and appears after the clock edge that captures the pixel.
- R3: In internal mode, `casc_o` is registered and equals the pixel captured 2R steps earlier, so it matches row 2, column 0. In bypass mode it still carries the internal two-row delay.
- R4: A length code of 0 selects R = 1024. Codes 1 to 1023 select R equal to the code.
- R5: The first length write accepted after reset takes effect. Every later write is ignored until the next reset.
- R6: The lockout counter starts at reset release and counts every clock, whether or not hold is high. A write is accepted only on clock edges 0 to 1023, counted from the first edge after reset release. After that the length stays at the 1024 setting unless it was already written.
- R7: With `bypass_i` high, row 1 takes `ext_rows_i[7:0]` and row 2 takes `ext_rows_i[15:8]` on each step.
- R8: `frame_clr_i` high clears the taps and the cascade output at the next edge, even while hold is high. After the clear, the delayed rows read zero until R (row 1) or 2R (row 2) new pixels have entered. The length register is unchanged.
- R9: `hold_i` is registered. When it was high at edge k, edge k+1 leaves the taps, the cascade output and the delay contents unchanged.
- R10: With R = 3, the nine taps after a step hold the last nine input pixels in order: row*3+col steps old for tap (row, col).
- R11: An accepted length write empties the delay lines and the taps, exactly as a frame clear does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Freeze request, takes effect one cycle after it is sampled |
| frame_clr_i | input | 1 | Synchronous clear of delay contents, taps and cascade |
| bypass_i | input | 1 | Take rows 1 and 2 from `ext_rows_i` |
| ext_rows_i | input | 16 | External rows: [7:0] row 1, [15:8] row 2 |
| pix_i | input | 8 | Raster pixel input |
| len_we_i | input | 1 | Row-length write strobe |
| len_wdata_i | input | 10 | Row-length code (0 means 1024) |
| taps_o | output | 72 | Nine 8-bit taps, layout per R2 |
| casc_o | output | 8 | Pixel delayed by two rows |

## Verification
The bench uses the default parameters: 8-bit pixels, 1024-deep delays and a 1024-clock write window. With these values the real boundaries are reachable. A write on edge 1023 is accepted and a write on edge 1024 is refused. With code 0 the bench streams more than 2048 pixels, so both the full 1024-pixel row delay and the 2048-pixel cascade delay are observed. Short lengths (3 and 5) keep the stream for write-once, hold, bypass, frame clear and the nine-sample window within a few dozen cycles.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int WIN_ROWS = 3;
  localparam int WIN_COLS = 3;

  // Length code 0 stands for the deepest setting.
  function automatic int len_decode(input int code, input int max_len);
    return (code == 0) ? max_len : code;
  endfunction

  // Bit offset of tap (row, col) in the flattened tap bus.
  function automatic int tap_lsb(input int row, input int col, input int pix_w);
    return pix_w * (row * WIN_COLS + col);
  endfunction
endpackage

// File: rtl/dly_len_ctl.sv
module dly_len_ctl #(
  parameter int LEN_W       = 10,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] len_code,
  output logic             accept,
  output logic             written,
  output logic             lock_done
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] lock_cnt;

  assign lock_done = (lock_cnt == CNT_W'(LOCK_CYCLES));
  assign accept    = we && !written && !lock_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
      len_code <= '0;
      written  <= 1'b0;
    end else begin
      if (!lock_done) lock_cnt <= lock_cnt + 1'b1;
      if (accept) begin
        len_code <= wdata;
        written  <= 1'b1;
      end else if (lock_done && !written) begin
        len_code <= '0;
      end
    end
  end
endmodule

// File: rtl/dly_ring.sv
module dly_ring #(
  parameter int PIX_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [LEN_W:0]   len,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout
);
  localparam int DEPTH = 1 << LEN_W;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [LEN_W-1:0] ptr;
  logic [LEN_W:0]   fill;
  logic             ptr_wrap;
  logic             filled;

  assign ptr_wrap = ({1'b0, ptr} == (len - 1'b1));
  assign filled   = (fill >= len);
  assign dout     = filled ? mem[ptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      fill <= '0;
    end else if (clr) begin
      ptr  <= '0;
      fill <= '0;
    end else if (step) begin
      ptr <= ptr_wrap ? '0 : ptr + 1'b1;
      if (!filled) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (step && !clr) mem[ptr] <= din;
  end
endmodule

// File: rtl/dly_window.sv
module dly_window #(
  parameter int PIX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic                          clr,
  input  logic [2:0][PIX_W-1:0]         row_in,
  output logic [2:0][2:0][PIX_W-1:0]    win_o
);
  for (genvar r = 0; r < dly_pkg::WIN_ROWS; r++) begin : g_row
    logic [2:0][PIX_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (clr)   sr_q <= '0;
      else if (step)  sr_q <= {sr_q[1], sr_q[0], row_in[r]};
    end

    assign win_o[r] = sr_q;
  end
endmodule

// File: rtl/dual_row_delay.sv
module dual_row_delay #(
  parameter int PIX_W       = 8,
  parameter int MAX_LEN     = 1024,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               frame_clr_i,
  input  logic               bypass_i,
  input  logic [2*PIX_W-1:0] ext_rows_i,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               len_we_i,
  input  logic [9:0]         len_wdata_i,
  output logic [9*PIX_W-1:0] taps_o,
  output logic [PIX_W-1:0]   casc_o
);
  localparam int LEN_W = $clog2(MAX_LEN);

  logic                          hold_q;
  logic                          step;
  logic                          clr;
  logic [LEN_W-1:0]              len_code;
  logic                          len_acc;
  logic                          len_written;
  logic                          lock_done;
  logic [LEN_W:0]                row_len;
  logic [PIX_W-1:0]              row1_int;
  logic [PIX_W-1:0]              row2_int;
  logic [2:0][PIX_W-1:0]         rows;
  logic [2:0][2:0][PIX_W-1:0]    win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_i;
  end

  assign step = !hold_q;
  assign clr  = frame_clr_i || len_acc;

  dly_len_ctl #(.LEN_W(LEN_W), .LOCK_CYCLES(LOCK_CYCLES)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (len_we_i),
    .wdata     (LEN_W'(len_wdata_i)),
    .len_code  (len_code),
    .accept    (len_acc),
    .written   (len_written),
    .lock_done (lock_done)
  );

  assign row_len = (LEN_W+1)'(dly_pkg::len_decode(int'(len_code), MAX_LEN));

  dly_ring #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_ring1 (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .clr   (clr),
    .len   (row_len),
    .din   (pix_i),
    .dout  (row1_int)
  );

  dly_ring #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_ring2 (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .clr   (clr),
    .len   (row_len),
    .din   (row1_int),
    .dout  (row2_int)
  );

  assign rows[0] = pix_i;
  assign rows[1] = bypass_i ? ext_rows_i[PIX_W-1:0]       : row1_int;
  assign rows[2] = bypass_i ? ext_rows_i[2*PIX_W-1:PIX_W] : row2_int;

  dly_window #(.PIX_W(PIX_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .clr    (clr),
    .row_in (rows),
    .win_o  (win)
  );

  assign taps_o = win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     casc_o <= '0;
    else if (clr)   casc_o <= '0;
    else if (step)  casc_o <= row2_int;
  end
endmodule

// File: rtl/dly_chk.sv
module dly_chk #(
  parameter int PIX_W = 8,
  parameter int LEN_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hold_q,
  input logic               frame_clr_i,
  input logic               bypass_i,
  input logic               len_acc,
  input logic               len_we_i,
  input logic               len_written,
  input logic               lock_done,
  input logic [LEN_W-1:0]   len_code,
  input logic [2*PIX_W-1:0] ext_rows_i,
  input logic [PIX_W-1:0]   pix_i,
  input logic [9*PIX_W-1:0] taps_o,
  input logic [PIX_W-1:0]   casc_o
);
  localparam int T00 = dly_pkg::tap_lsb(0, 0, PIX_W);
  localparam int T01 = dly_pkg::tap_lsb(0, 1, PIX_W);
  localparam int T10 = dly_pkg::tap_lsb(1, 0, PIX_W);
  localparam int T20 = dly_pkg::tap_lsb(2, 0, PIX_W);

  logic adv;
  assign adv = !hold_q && !frame_clr_i && !len_acc;

  AST_ROW0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> taps_o[T00 +: PIX_W] == $past(pix_i)); // R2
  AST_COL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> taps_o[T01 +: PIX_W] == $past(taps_o[T00 +: PIX_W])); // R2
  AST_CASC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && !hold_q) |=> casc_o == taps_o[T20 +: PIX_W]); // R3
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_written && len_we_i) |=> $stable(len_code)); // R5
  AST_LOCK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_done && len_we_i) |=> $stable(len_code)); // R6
  AST_BYPASS_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bypass_i) |=> taps_o[T10 +: PIX_W] == $past(ext_rows_i[PIX_W-1:0])); // R7
  AST_BYPASS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bypass_i) |=> taps_o[T20 +: PIX_W] == $past(ext_rows_i[2*PIX_W-1:PIX_W])); // R7
  AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr_i |=> (taps_o == '0) && (casc_o == '0)); // R8
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !frame_clr_i && !len_acc) |=> $stable(taps_o) && $stable(casc_o)); // R9
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    len_acc |=> (taps_o == '0) && (casc_o == '0)); // R11
endmodule

bind dual_row_delay dly_chk #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_q      (hold_q),
  .frame_clr_i (frame_clr_i),
  .bypass_i    (bypass_i),
  .len_acc     (len_acc),
  .len_we_i    (len_we_i),
  .len_written (len_written),
  .lock_done   (lock_done),
  .len_code    (len_code),
  .ext_rows_i  (ext_rows_i),
  .pix_i       (pix_i),
  .taps_o      (taps_o),
  .casc_o      (casc_o)
);

// File: tb/dual_row_delay_tb.sv
`timescale 1ns/100ps
module dual_row_delay_tb;
  localparam int MAXL = 1024;
  localparam int LOCK = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_i = 1'b0, frame_clr_i = 1'b0, bypass_i = 1'b0, len_we_i = 1'b0;
  logic [15:0] ext_rows_i = '0;
  logic [7:0]  pix_i = '0;
  logic [9:0]  len_wdata_i = '0;
  logic [71:0] taps_o;
  logic [7:0]  casc_o;

  always #2.5 clk = ~clk;

  dual_row_delay u_dut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .frame_clr_i(frame_clr_i),
    .bypass_i(bypass_i), .ext_rows_i(ext_rows_i), .pix_i(pix_i),
    .len_we_i(len_we_i), .len_wdata_i(len_wdata_i), .taps_o(taps_o), .casc_o(casc_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int         m_len, m_n, m_cyc;
  bit         m_hold, m_written;
  logic [7:0] m_hist[$];
  logic [7:0] m_tap[3][3];
  logic [7:0] m_casc;

  logic [71:0] q_taps[$];
  logic [7:0]  q_casc[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_len = MAXL; m_n = 0; m_cyc = 0; m_hold = 0; m_written = 0;
    m_hist.delete(); m_casc = '0;
    for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) m_tap[r][c] = '0;
  endfunction

  // Called at a falling edge: applies inputs, predicts the next rising edge.
  task automatic drive(input logic [7:0] p, input bit h, input bit f, input bit b,
                       input logic [15:0] e, input bit we, input logic [9:0] wd,
                       input string tag);
    bit acc;
    logic [7:0] rw [3];
    logic [7:0] r1, r2;
    logic [71:0] et;
    pix_i = p; hold_i = h; frame_clr_i = f; bypass_i = b; ext_rows_i = e;
    len_we_i = we; len_wdata_i = wd;
    acc = we && !m_written && (m_cyc < LOCK);
    if (f || acc) begin
      m_n = 0; m_hist.delete(); m_casc = '0;
      for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) m_tap[r][c] = '0;
    end else if (!m_hold) begin
      r1 = (m_n >= m_len)     ? m_hist[m_len-1]   : 8'h00;
      r2 = (m_n >= 2 * m_len) ? m_hist[2*m_len-1] : 8'h00;
      rw[0] = p;
      rw[1] = b ? e[7:0]  : r1;
      rw[2] = b ? e[15:8] : r2;
      for (int r = 0; r < 3; r++) begin
        m_tap[r][2] = m_tap[r][1]; m_tap[r][1] = m_tap[r][0]; m_tap[r][0] = rw[r];
      end
      m_casc = r2;
      m_hist.push_front(p);
      if (m_hist.size() > 2 * MAXL + 4) void'(m_hist.pop_back());
      m_n++;
    end
    if (acc) begin
      m_len = (wd == 0) ? MAXL : int'(wd);
      m_written = 1;
    end
    m_hold = h;
    if (m_cyc < LOCK) m_cyc++;
    for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) et[8*(3*r+c) +: 8] = m_tap[r][c];
    q_taps.push_back(et); q_casc.push_back(m_casc); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(8'h00, 0, 0, 0, 16'h0, 0, 10'd0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pix_i = '0; hold_i = 0; frame_clr_i = 0; bypass_i = 0;
    ext_rows_i = '0; len_we_i = 0; len_wdata_i = '0;
    repeat (3) @(negedge clk);
    check("R1", {taps_o, casc_o}, 80'h0);
    rst_n = 1;
    model_reset();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_taps.size() > 0) begin
        logic [71:0] et;
        logic [7:0]  ec;
        string       tg;
        et = q_taps.pop_front(); ec = q_casc.pop_front(); tg = q_tag.pop_front();
        check({tg, " taps"}, {8'h00, taps_o}, {8'h00, et});
        check({tg, " casc"}, {72'h0, casc_o}, {72'h0, ec});
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11: pixels with default length, then accepted write clears the window
    for (int i = 0; i < 12; i++) drive(8'(i + 1), 0, 0, 0, 16'h0, 0, 10'd0, "R11");
    drive(8'hA5, 0, 0, 0, 16'h0, 1, 10'd5, "R11");
    // R2 R3: stream with R = 5
    for (int i = 0; i < 30; i++) drive(8'(i * 7 + 3), 0, 0, 0, 16'h0, 0, 10'd0, "R2 R3");
    // R5: second write ignored
    drive(8'h44, 0, 0, 0, 16'h0, 1, 10'd9, "R5");
    for (int i = 0; i < 30; i++) drive(8'(i * 13 + 1), 0, 0, 0, 16'h0, 0, 10'd0, "R5");
    // R9: hold pattern
    for (int i = 0; i < 20; i++) drive(8'(i + 200), (i % 3) == 0, 0, 0, 16'h0, 0, 10'd0, "R9");
    // R7: bypass
    for (int i = 0; i < 15; i++)
      drive(8'(i + 9), 0, 0, 1, {8'(i + 100), 8'(i + 50)}, 0, 10'd0, "R7");
    // R8: frame clear during hold, then refill
    drive(8'h11, 1, 1, 0, 16'h0, 0, 10'd0, "R8");
    for (int i = 0; i < 20; i++) drive(8'(i * 3 + 60), 0, 0, 0, 16'h0, 0, 10'd0, "R8");

    // R6 boundary accept on edge 1023, then R10 nine-sample window
    do_reset();
    idle(1023, "R6");
    drive(8'h00, 0, 0, 0, 16'h0, 1, 10'd3, "R6");
    for (int i = 0; i < 25; i++) drive(8'(i * 11 + 5), 0, 0, 0, 16'h0, 0, 10'd0, "R10");

    // R6 refused on edge 1024, R4 full 1024 delay
    do_reset();
    idle(1024, "R6");
    drive(8'h00, 0, 0, 0, 16'h0, 1, 10'd4, "R6");
    for (int i = 0; i < 2 * MAXL + 20; i++)
      drive(8'(i * 5 + 7), 0, 0, 0, 16'h0, 0, 10'd0, "R4 R3");

    @(posedge clk); #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule